// File: doc/BRIEF.md
# Module-Slot Local Bus Decoder

This block sits between a host local-bus window and four plug-in module slots. Each host access carries an address, a byte or halfword size, a write flag and write data. The decoder splits the address into three fields: a slot index, an address-space selector and an offset. It then presents a one-hot request to the addressed slot. The request carries a space code (I/O, ID or interrupt), the masked offset, the access size and the write data. The decoder holds that request until the slot signals ready, and then returns the slot's read data to the host as a single-cycle response.

A configuration write port holds one big-endian flag per host window. The flag of the window this decoder serves controls two things: it flips address bit 0 for byte accesses, and it swaps the two data bytes of halfword accesses in both directions. Slots that are absent or out of range are not forwarded. They still answer the host, with zero read data. A read of offset 0 or 2 in a slot's interrupt space also produces a one-cycle acknowledge pulse toward the interrupt logic, provided that the interrupt line is pending and level sensitive.

Top module: `slot_bus_decoder`

## Requirements
- R1: After reset the decoder has no slot request raised, no response valid and no acknowledge pulse, and `req_ready_o` is high; every big-endian flag is cleared.
- R2: The slot index is address bits [ADDR_W-1:8]. An accepted access to a present slot raises exactly bit `index` of `slot_req_o`. An index of NSLOT or more, or a slot whose `slot_present_i` bit is low, raises no request; the response then arrives the cycle after acceptance, with read data zero, and the write is discarded.
- R3: Address bits [7:6] select the space. The value 2 gives the ID space (output code 1) with offset bits [5:0]. The value 3 gives the interrupt space (output code 2) with offset bits [5:0]. The values 0 and 1 give the I/O space (output code 0) with offset bits [6:0].
- R4: When the served window's big-endian flag is set, a byte access (`req_size_i`=0) has address bit 0 inverted before any field is decoded. Halfword accesses and little-endian mode use the address unchanged.
- R5: When the flag is set, a halfword access (`req_size_i`=1) swaps the upper and lower bytes of the write data sent to the slot and of the read data returned to the host. Byte accesses pass data unswapped.
- R6: A configuration write at byte offset 0x2B, 0x2F or 0x33 stores `cfg_wbit_i` as the flag of window (offset-0x2B)/4. The decoder uses window WIN_SEL (default 1, offset 0x2F). Writes to any other offset change no flag.
- R7: A read accepted to a present slot, in the interrupt space, at offset 0 or 2, selects line offset/2. Its pending and edge bits are at index slot*2+line of `irq_pend_i` and `irq_edge_i`. If that line is pending and its edge bit is 0, `irq_ack_o` pulses for the one cycle after acceptance, with the slot and line on `irq_ack_slot_o` and `irq_ack_line_o`. Writes, other offsets, edge-configured lines, non-pending lines and absent slots give no pulse.
- R8: A slot request stays asserted, with its fields stable, until that slot's `slot_ready_i` bit is high. `rsp_valid_o` pulses for one cycle on the cycle after the ready edge, carrying that slot's `slot_rdata_i` lane (zero for writes). `req_ready_o` is low from acceptance until after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wbit_i | input | 1 | Bit 0 of the configuration write data |
| req_valid_i | input | 1 | Host access valid |
| req_ready_o | output | 1 | Host access accepted when high with valid |
| req_addr_i | input | ADDR_W | Host access address |
| req_size_i | input | 1 | 0 = byte, 1 = halfword |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Host write data |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_rdata_o | output | DATA_W | Response read data |
| slot_present_i | input | NSLOT | Module installed per slot |
| slot_req_o | output | NSLOT | One-hot slot request |
| slot_space_o | output | 2 | Space code: 0 I/O, 1 ID, 2 interrupt |
| slot_offset_o | output | 7 | Masked offset within the space |
| slot_we_o | output | 1 | Slot write flag |
| slot_size_o | output | 1 | Slot access size |
| slot_wdata_o | output | DATA_W | Lane-adjusted write data |
| slot_ready_i | input | NSLOT | Per-slot completion |
| slot_rdata_i | input | NSLOT*DATA_W | Per-slot read data, slot k at [k*DATA_W +: DATA_W] |
| irq_pend_i | input | 2*NSLOT | Pending interrupt lines |
| irq_edge_i | input | 2*NSLOT | Edge-sensitive configuration per line |
| irq_ack_o | output | 1 | Acknowledge pulse |
| irq_ack_slot_o | output | $clog2(NSLOT) | Acknowledged slot |
| irq_ack_line_o | output | 1 | Acknowledged line |

## Verification
The bench drives a byte access at an odd interrupt-space address with the big-endian flag set. A decoder that swaps lanes after decoding, rather than before, would send the wrong offset and miss or misroute the acknowledge. The bench also addresses slot 5, which is out of range, and a slot marked absent. A decoder that simply truncated the slot index would forward the access to slot 1. One that ignored the present vector would hang waiting for a ready that never comes. The acknowledge pulse is exercised against writes, edge-configured lines, lines that are not pending and non-zero offsets; a loose qualifier would fire on any of them. Configuration writes to neighbouring offsets check that only the served window's flag alters the lanes.

// File: rtl/slotdec_pkg.sv
package slotdec_pkg;
  typedef enum logic [1:0] {
    SPC_IO  = 2'd0,
    SPC_ID  = 2'd1,
    SPC_INT = 2'd2
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_RESP
  } state_e;
endpackage

// File: rtl/slot_cfg_endian.sv
module slot_cfg_endian #(
  parameter int          NWIN   = 3,
  parameter logic [7:0]  BASE   = 8'h2B,
  parameter int          STRIDE = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_addr_i,
  input  logic            cfg_wbit_i,
  output logic [NWIN-1:0] be_o
);
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [7:0] OFF = 8'(int'(BASE) + w * STRIDE);
    logic be_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              be_q <= 1'b0;
      else if (cfg_we_i && cfg_addr_i == OFF)   be_q <= cfg_wbit_i;
    end
    assign be_o[w] = be_q;
  end
endmodule

// File: rtl/slot_addr_decode.sv
module slot_addr_decode import slotdec_pkg::*; #(
  parameter  int NSLOT  = 4,
  parameter  int ADDR_W = 11,
  localparam int SEL_W  = $clog2(NSLOT)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  slot_o,
  output space_e            space_o,
  output logic [6:0]        off_o
);
  localparam int SIDX_W = ADDR_W - 8;

  logic [SIDX_W-1:0] idx;
  assign idx    = addr_i[ADDR_W-1:8];
  assign hit_o  = idx < SIDX_W'(NSLOT);
  assign slot_o = idx[SEL_W-1:0];

  always_comb begin
    unique case (addr_i[7:6])
      2'b10:   begin space_o = SPC_ID;  off_o = {1'b0, addr_i[5:0]}; end
      2'b11:   begin space_o = SPC_INT; off_o = {1'b0, addr_i[5:0]}; end
      default: begin space_o = SPC_IO;  off_o = addr_i[6:0];         end
    endcase
  end
endmodule

// File: rtl/slot_lane_swap.sv
module slot_lane_swap #(
  parameter int W = 16
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  localparam int H = W / 2;
  assign d_o = en_i ? {d_i[H-1:0], d_i[W-1:H]} : d_i;
endmodule

// File: rtl/slot_bus_decoder.sv
module slot_bus_decoder import slotdec_pkg::*; #(
  parameter  int NSLOT   = 4,
  parameter  int ADDR_W  = 11,
  parameter  int DATA_W  = 16,
  parameter  int NWIN    = 3,
  parameter  int WIN_SEL = 1,
  localparam int SEL_W   = $clog2(NSLOT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [7:0]              cfg_addr_i,
  input  logic                    cfg_wbit_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic                    req_size_i,
  input  logic                    req_we_i,
  input  logic [DATA_W-1:0]       req_wdata_i,
  output logic                    rsp_valid_o,
  output logic [DATA_W-1:0]       rsp_rdata_o,
  input  logic [NSLOT-1:0]        slot_present_i,
  output logic [NSLOT-1:0]        slot_req_o,
  output logic [1:0]              slot_space_o,
  output logic [6:0]              slot_offset_o,
  output logic                    slot_we_o,
  output logic                    slot_size_o,
  output logic [DATA_W-1:0]       slot_wdata_o,
  input  logic [NSLOT-1:0]        slot_ready_i,
  input  logic [NSLOT*DATA_W-1:0] slot_rdata_i,
  input  logic [2*NSLOT-1:0]      irq_pend_i,
  input  logic [2*NSLOT-1:0]      irq_edge_i,
  output logic                    irq_ack_o,
  output logic [SEL_W-1:0]        irq_ack_slot_o,
  output logic                    irq_ack_line_o
);
  localparam int LINE_W = SEL_W + 1;

  logic [NWIN-1:0] be_win;
  logic            be;

  slot_cfg_endian #(.NWIN(NWIN)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wbit_i, .be_o(be_win)
  );
  assign be = be_win[WIN_SEL];

  // byte lane flip happens ahead of field decode
  logic [ADDR_W-1:0] adj_addr;
  assign adj_addr = req_addr_i ^ {{(ADDR_W-1){1'b0}}, be & ~req_size_i};

  logic             dec_hit;
  logic [SEL_W-1:0] dec_slot;
  space_e           dec_space;
  logic [6:0]       dec_off;

  slot_addr_decode #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(adj_addr), .hit_o(dec_hit), .slot_o(dec_slot),
    .space_o(dec_space), .off_o(dec_off)
  );

  logic swap_in;
  logic [DATA_W-1:0] wdata_sw;
  assign swap_in = be & req_size_i;

  slot_lane_swap #(.W(DATA_W)) u_wsw (
    .en_i(swap_in), .d_i(req_wdata_i), .d_o(wdata_sw)
  );

  logic present;
  assign present = dec_hit && slot_present_i[dec_slot];

  logic              ack_line;
  logic [LINE_W-1:0] ack_idx;
  logic              ack_hit;
  assign ack_line = dec_off[1];
  assign ack_idx  = {dec_slot, ack_line};
  assign ack_hit  = !req_we_i && present && dec_space == SPC_INT &&
                    dec_off[5:2] == 4'd0 && !dec_off[0] &&
                    irq_pend_i[ack_idx] && !irq_edge_i[ack_idx];

  state_e            state_q;
  logic [SEL_W-1:0]  slot_q;
  space_e            space_q;
  logic [6:0]        off_q;
  logic              we_q, size_q, swap_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              ack_q, ack_line_q;
  logic [SEL_W-1:0]  ack_slot_q;

  logic              accept;
  logic [DATA_W-1:0] rsel, rsel_sw;
  assign accept = req_valid_i && state_q == ST_IDLE;
  assign rsel   = slot_rdata_i[slot_q*DATA_W +: DATA_W];

  slot_lane_swap #(.W(DATA_W)) u_rsw (
    .en_i(swap_q), .d_i(rsel), .d_o(rsel_sw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      space_q <= SPC_IO;
      off_q   <= '0;
      we_q    <= 1'b0;
      size_q  <= 1'b0;
      swap_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          slot_q  <= dec_slot;
          space_q <= dec_space;
          off_q   <= dec_off;
          we_q    <= req_we_i;
          size_q  <= req_size_i;
          swap_q  <= swap_in;
          wdata_q <= wdata_sw;
          rdata_q <= '0;
          state_q <= present ? ST_BUSY : ST_RESP;
        end
        ST_BUSY: if (slot_ready_i[slot_q]) begin
          rdata_q <= we_q ? '0 : rsel_sw;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q      <= 1'b0;
      ack_slot_q <= '0;
      ack_line_q <= 1'b0;
    end else begin
      ack_q <= accept && ack_hit;
      if (accept && ack_hit) begin
        ack_slot_q <= dec_slot;
        ack_line_q <= ack_line;
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_req
    assign slot_req_o[s] = state_q == ST_BUSY && slot_q == SEL_W'(s);
  end

  assign req_ready_o    = state_q == ST_IDLE;
  assign rsp_valid_o    = state_q == ST_RESP;
  assign rsp_rdata_o    = rdata_q;
  assign slot_space_o   = space_q;
  assign slot_offset_o  = off_q;
  assign slot_we_o      = we_q;
  assign slot_size_o    = size_q;
  assign slot_wdata_o   = wdata_q;
  assign irq_ack_o      = ack_q;
  assign irq_ack_slot_o = ack_slot_q;
  assign irq_ack_line_o = ack_line_q;
endmodule

// File: rtl/slot_bus_decoder_chk.sv
module slot_bus_decoder_chk #(
  parameter int NSLOT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_we_i,
  input logic             rsp_valid_o,
  input logic [NSLOT-1:0] slot_req_o,
  input logic [NSLOT-1:0] slot_ready_i,
  input logic [6:0]       slot_offset_o,
  input logic             irq_ack_o
);
  p_req_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_req_o));

  p_ack_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o);

  p_ack_after_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> $past(req_valid_i && req_ready_o && !req_we_i));

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slot_req_o && !(|(slot_req_o & slot_ready_i))) |=>
      ($stable(slot_req_o) && $stable(slot_offset_o)));

  p_busy_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slot_req_o) |-> !req_ready_o);

  p_rsp_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_done_then_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(slot_req_o & slot_ready_i)) |=> rsp_valid_o);
endmodule

bind slot_bus_decoder slot_bus_decoder_chk #(.NSLOT(NSLOT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_we_i(req_we_i), .rsp_valid_o(rsp_valid_o),
  .slot_req_o(slot_req_o), .slot_ready_i(slot_ready_i),
  .slot_offset_o(slot_offset_o), .irq_ack_o(irq_ack_o)
);

// File: tb/slot_bus_decoder_tb.sv
module slot_bus_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 4, ADDR_W = 11, DATA_W = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                    cfg_we = 0, cfg_wbit = 0;
  logic [7:0]              cfg_addr = 0;
  logic                    req_valid = 0, req_size = 0, req_we = 0;
  logic [ADDR_W-1:0]       req_addr = 0;
  logic [DATA_W-1:0]       req_wdata = 0;
  logic                    req_ready, rsp_valid;
  logic [DATA_W-1:0]       rsp_rdata;
  logic [NSLOT-1:0]        present = '1;
  logic [NSLOT-1:0]        slot_req, slot_ready;
  logic [1:0]              slot_space;
  logic [6:0]              slot_off;
  logic                    slot_we, slot_size;
  logic [DATA_W-1:0]       slot_wdata;
  logic [NSLOT*DATA_W-1:0] slot_rdata;
  logic [2*NSLOT-1:0]      pend = '0, edge_cfg = '0;
  logic                    ack, ack_line;
  logic [1:0]              ack_slot;
  logic                    ready_en = 1'b1;

  for (genvar k = 0; k < NSLOT; k++) begin : g_rd
    assign slot_rdata[k*DATA_W +: DATA_W] = {8'(8'h10 + k), 8'(8'h80 + k)};
  end
  assign slot_ready = slot_req & {NSLOT{ready_en}};

  slot_bus_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wbit_i(cfg_wbit), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_we_i(req_we),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .slot_present_i(present), .slot_req_o(slot_req), .slot_space_o(slot_space),
    .slot_offset_o(slot_off), .slot_we_o(slot_we), .slot_size_o(slot_size),
    .slot_wdata_o(slot_wdata), .slot_ready_i(slot_ready),
    .slot_rdata_i(slot_rdata), .irq_pend_i(pend), .irq_edge_i(edge_cfg),
    .irq_ack_o(ack), .irq_ack_slot_o(ack_slot), .irq_ack_line_o(ack_line)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // observations of one access
  logic [NSLOT-1:0]  o_req;
  logic [1:0]        o_space;
  logic [6:0]        o_off;
  logic [DATA_W-1:0] o_wdata, o_rd;
  logic              o_ack, o_ack_line;
  logic [1:0]        o_ack_slot;
  int                o_lat;

  task automatic access(input logic [ADDR_W-1:0] a, input logic sz, input logic we,
                        input logic [DATA_W-1:0] wd);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_we = we; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    o_req = slot_req; o_space = slot_space; o_off = slot_off; o_wdata = slot_wdata;
    o_ack = ack; o_ack_slot = ack_slot; o_ack_line = ack_line;
    o_lat = 0;
    for (int i = 0; i < 20 && !rsp_valid; i++) begin
      @(negedge clk);
      o_lat++;
    end
    o_rd = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic b);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wbit = b;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic t_reset;
    check("R1 req during reset", slot_req, 0);
    check("R1 rsp during reset", rsp_valid, 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    check("R1 req after reset", slot_req, 0);
    check("R1 ready after reset", req_ready, 1);
    check("R1 ack after reset", ack, 0);
    check("R1 rsp after reset", rsp_valid, 0);
    access(11'h104, 0, 0, 0);
    check("R1 little endian default offset", o_off, 7'h04);
  endtask

  task automatic t_decode;
    access(11'h1C5, 1, 0, 0);
    check("R2 slot1 req", o_req, 4'b0010);
    check("R3 int space", o_space, 2);
    check("R3 int offset", o_off, 7'h05);
    check("R8 slot1 rdata", o_rd, 16'h1181);
    check("R8 latency present", o_lat, 1);
    access(11'h2A7, 1, 1, 16'hBEEF);
    check("R2 slot2 req", o_req, 4'b0100);
    check("R3 id space", o_space, 1);
    check("R3 id offset", o_off, 7'h27);
    check("R8 write data", o_wdata, 16'hBEEF);
    check("R8 write rdata zero", o_rd, 0);
    access(11'h37F, 1, 0, 0);
    check("R3 io space code1", o_space, 0);
    check("R3 io 7-bit offset", o_off, 7'h7F);
    check("R8 slot3 rdata", o_rd, 16'h1383);
    access(11'h025, 0, 0, 0);
    check("R2 slot0 req", o_req, 4'b0001);
    check("R3 io offset", o_off, 7'h25);
  endtask

  task automatic t_empty;
    present = 4'b1011;
    access(11'h2A7, 1, 0, 0);
    check("R2 absent no req", o_req, 0);
    check("R2 absent rdata zero", o_rd, 0);
    check("R2 absent latency", o_lat, 0);
    access(11'h200, 1, 1, 16'h5555);
    check("R2 absent write discarded", o_req, 0);
    access(11'h540, 1, 0, 0);
    check("R2 out of range no req", o_req, 0);
    check("R2 out of range rdata", o_rd, 0);
    present = '1;
  endtask

  task automatic t_be;
    cfg_write(8'h2F, 1);
    access(11'h104, 0, 0, 0);
    check("R4 byte addr flip", o_off, 7'h05);
    check("R5 byte read unswapped", o_rd, 16'h1181);
    access(11'h1C1, 0, 1, 16'h00AB);
    check("R4 byte flip into int space", o_off, 7'h00);
    check("R5 byte write unswapped", o_wdata, 16'h00AB);
    check("R7 no ack on write", o_ack, 0);
    access(11'h104, 1, 0, 0);
    check("R4 halfword no flip", o_off, 7'h04);
    check("R5 halfword read swapped", o_rd, 16'h8111);
    access(11'h110, 1, 1, 16'h1234);
    check("R5 halfword write swapped", o_wdata, 16'h3412);
    cfg_write(8'h2F, 0);
    access(11'h110, 1, 0, 0);
    check("R5 little endian read", o_rd, 16'h1181);
  endtask

  task automatic t_cfg;
    cfg_write(8'h2B, 1);
    cfg_write(8'h33, 1);
    cfg_write(8'h2E, 1);
    cfg_write(8'h30, 1);
    access(11'h104, 0, 0, 0);
    check("R6 other windows ignored", o_off, 7'h04);
    cfg_write(8'h2F, 1);
    access(11'h104, 0, 0, 0);
    check("R6 served window set", o_off, 7'h05);
    cfg_write(8'h2F, 0);
    cfg_write(8'h2B, 0);
    cfg_write(8'h33, 0);
  endtask

  task automatic t_ack;
    pend = '1; edge_cfg = '0;
    access(11'h1C0, 0, 0, 0);
    check("R7 ack slot1 line0", o_ack, 1);
    check("R7 ack slot", o_ack_slot, 1);
    check("R7 ack line", o_ack_line, 0);
    check("R7 pulse cleared", ack, 0);
    access(11'h3C2, 1, 0, 0);
    check("R7 ack slot3 line1", {o_ack, o_ack_slot, o_ack_line}, 4'b1111);
    access(11'h1C4, 1, 0, 0);
    check("R7 no ack other offset", o_ack, 0);
    access(11'h1C0, 1, 1, 0);
    check("R7 no ack write", o_ack, 0);
    edge_cfg[2] = 1;
    access(11'h1C0, 1, 0, 0);
    check("R7 no ack edge line", o_ack, 0);
    edge_cfg = '0; pend[2] = 0;
    access(11'h1C0, 1, 0, 0);
    check("R7 no ack not pending", o_ack, 0);
    pend = '1; present = 4'b1101;
    access(11'h1C0, 1, 0, 0);
    check("R7 no ack absent slot", o_ack, 0);
    present = '1;
    access(11'h0C2, 1, 0, 0);
    check("R7 ack slot0 line1", {o_ack, o_ack_slot, o_ack_line}, 4'b1001);
    cfg_write(8'h2F, 1);
    access(11'h1C3, 0, 0, 0);
    check("R7 ack via byte flip", {o_ack, o_ack_slot, o_ack_line}, 4'b1011);
    cfg_write(8'h2F, 0);
    pend = '0;
  endtask

  task automatic t_stall;
    ready_en = 0;
    @(negedge clk);
    req_valid = 1; req_addr = 11'h245; req_size = 1; req_we = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3; i++) begin
      check("R8 req held", slot_req, 4'b0100);
      check("R8 offset held", slot_off, 7'h45);
      check("R8 no rsp while stalled", rsp_valid, 0);
      check("R8 busy not ready", req_ready, 0);
      @(negedge clk);
    end
    ready_en = 1;
    @(negedge clk);
    check("R8 rsp after ready", rsp_valid, 1);
    check("R8 stalled rdata", rsp_rdata, 16'h1282);
    check("R8 req dropped", slot_req, 0);
    @(negedge clk);
    check("R8 rsp single", rsp_valid, 0);
    check("R8 ready again", req_ready, 1);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_empty();
    t_be();
    t_cfg();
    t_ack();
    t_stall();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule